// File: doc/BRIEF.md
# Pinned-Write Register Rename Table

This block is the rename table of an out-of-order core. It holds, for each architectural register index, the physical register tag that currently backs it. New tags come from a first-in first-out free list. The commit side hands freed tags back through a return port. Each cycle one rename request can arrive, carrying an architectural index, an invalid-class marker and a pinned-write count. The table answers one cycle later with the new tag and the tag that was mapped before.

A vector instruction that is split into many micro-ops can pin its destination. The first micro-op allocates a tag and loads that tag's pinned-write counter with the number of micro-ops still to come, up to 16 or more. Each later micro-op finds the counter above zero, so it reuses the same tag and decrements the counter. It does not pop the free list. Every tag also carries a writes-to-complete counter, loaded with the pinned count plus one.

Squash requests name the pinned physical tag of an instruction. A squash for re-execution returns one pinned write to the counter. A squash caused by a fault clears the counter, so the restarted instruction allocates afresh. A request that tries to pin a register that is already pinned sets a sticky error flag.

Top module: `pin_rename_map`

## Requirements
- R1: After reset, architectural index i maps to physical tag i. The free list holds tags 32 to 63 with 32 at its head. All counters are zero, and out_valid, err_flag and ren_stall are low.
- R2: A valid request whose current tag has a pinned-write count of zero, and which is not invalid-class, pops the head of the free list. On the next cycle it reports that tag as out_new_tag and the old mapping as out_prev_tag, with out_valid high. The popped tag's pinned-write count becomes ren_pin_cnt.
- R3: An invalid-class request (ren_invalid=1) changes no state and reports the current mapping as both out_new_tag and out_prev_tag.
- R4: When the currently mapped tag has a pinned-write count above zero and ren_pin_cnt is zero, the request reuses that tag for both outputs and does not pop the free list. The count drops by one. A count of 16 gives exactly 16 reuses before the next fresh allocation.
- R5: When the pinned-reuse case is reached with a nonzero ren_pin_cnt, err_flag rises and stays high until reset. No state changes, and both output tags equal the current mapping.
- R6: A squash with sq_fault=0 on a pinned tag (one last allocated with a nonzero count) adds one to its pinned-write count. With sq_written=1 it also adds one to the writes-to-complete count. A squash on a tag that is not pinned has no effect.
- R7: A tag's squash is applied at most once between two renames that touch that tag. Later squashes of the same tag are ignored until a rename reuses or reallocates it.
- R8: A squash with sq_fault=1 on a pinned tag clears its pinned-write count to zero. The next rename of that architectural index therefore takes a fresh tag without raising err_flag.
- R9: A request that needs a fresh tag while the free list is empty raises ren_stall in the same cycle. It changes no state and produces no out_valid.
- R10: A rename request in the same cycle as sq_valid is stalled (ren_stall high), while the squash takes effect.
- R11: Returned tags enter the free list in order and are handed out in that order. A tag returned in a cycle when the list is empty cannot serve a request in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_invalid | input | 1 | Request names an invalid-class register |
| ren_arch | input | 5 | Architectural register index |
| ren_pin_cnt | input | 5 | Pinned-write count carried by the request |
| ren_stall | output | 1 | Request cannot be accepted this cycle |
| out_valid | output | 1 | Registered result of an accepted request |
| out_new_tag | output | 6 | Physical tag now mapped |
| out_prev_tag | output | 6 | Physical tag mapped before the request |
| err_flag | output | 1 | Sticky illegal double-pin indicator |
| sq_valid | input | 1 | Squash request present |
| sq_fault | input | 1 | Squash caused by a fault |
| sq_written | input | 1 | Squashed instruction had already written its destination |
| sq_tag | input | 6 | Pinned physical destination of the squashed instruction |
| fl_ret_valid | input | 1 | Freed tag returned to the free list |
| fl_ret_tag | input | 6 | Returned tag |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a rename request and a squash. The bench drives both together, expects ren_stall high in that cycle, and then checks through later reuse counts that the squash still adjusted the pinned counter. The second pair is a fresh allocation and a tag return while the free list is empty. Here the request must still stall, and the returned tag must come out on the following accepted rename.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int DEF_ARCH_REGS = 32;
  localparam int DEF_PHYS_REGS = 64;
  localparam int DEF_CNT_W     = 5;

  typedef enum logic [1:0] {
    RP_INVALID = 2'd0,
    RP_REUSE   = 2'd1,
    RP_DBLPIN  = 2'd2,
    RP_FRESH   = 2'd3
  } ren_path_e;
endpackage

// File: rtl/rmap_free_fifo.sv
module rmap_free_fifo #(
  parameter int DEPTH   = 64,
  parameter int W       = 6,
  parameter int INIT_LO = 32,
  parameter int INIT_N  = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_tag,
  input  logic         pop,
  output logic [W-1:0] head_tag,
  output logic         empty
);
  localparam int PTW = $clog2(DEPTH);
  localparam int CTW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [PTW-1:0] rd_ptr, wr_ptr;
  logic [CTW-1:0] count;
  logic           full, push_ok, pop_ok;

  assign empty    = (count == '0);
  assign full     = (count == CTW'(DEPTH));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign head_tag = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) begin
        mem[j] <= (j < INIT_N) ? W'(INIT_LO + j) : '0;
      end
      rd_ptr <= '0;
      wr_ptr <= PTW'(INIT_N % DEPTH);
      count  <= CTW'(INIT_N);
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= push_tag;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rmap_pin_table.sv
module rmap_pin_table #(
  parameter int PHYS_REGS = 64,
  parameter int PW        = 6,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    rd_tag,
  output logic [CNT_W-1:0] rd_pin,
  input  logic             alloc,
  input  logic             reuse,
  input  logic [PW-1:0]    upd_tag,
  input  logic [CNT_W-1:0] upd_cnt,
  input  logic             sq_valid,
  input  logic             sq_fault,
  input  logic             sq_written,
  input  logic [PW-1:0]    sq_tag
);
  localparam int WW = CNT_W + 1;

  logic [CNT_W-1:0] pin_q [PHYS_REGS];
  logic [WW-1:0]    wtc_q [PHYS_REGS];
  logic [PHYS_REGS-1:0] sqd_q;
  logic             sq_apply;
  logic [CNT_W-1:0] sq_pin;
  logic [WW-1:0]    sq_wtc;

  assign rd_pin = pin_q[rd_tag];
  assign sq_pin = pin_q[sq_tag];
  assign sq_wtc = wtc_q[sq_tag];
  // a tag is pinned when its writes-to-complete exceeds one
  assign sq_apply = sq_valid && (sq_wtc > WW'(1)) && !sqd_q[sq_tag];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < PHYS_REGS; j++) begin
        pin_q[j] <= '0;
        wtc_q[j] <= '0;
      end
      sqd_q <= '0;
    end else begin
      if (alloc) begin
        pin_q[upd_tag] <= upd_cnt;
        wtc_q[upd_tag] <= {1'b0, upd_cnt} + WW'(1);
        sqd_q[upd_tag] <= 1'b0;
      end else if (reuse) begin
        pin_q[upd_tag] <= pin_q[upd_tag] - 1'b1;
        sqd_q[upd_tag] <= 1'b0;
      end
      if (sq_apply) begin
        if (sq_fault) begin
          pin_q[sq_tag] <= '0;
        end else begin
          if (sq_pin != '1) pin_q[sq_tag] <= sq_pin + 1'b1;
          if (sq_written && (sq_wtc != '1)) wtc_q[sq_tag] <= sq_wtc + 1'b1;
        end
        sqd_q[sq_tag] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pin_rename_map.sv
module pin_rename_map
  import rmap_pkg::*;
#(
  parameter int ARCH_REGS = DEF_ARCH_REGS,
  parameter int PHYS_REGS = DEF_PHYS_REGS,
  parameter int CNT_W     = DEF_CNT_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ren_valid,
  input  logic                         ren_invalid,
  input  logic [$clog2(ARCH_REGS)-1:0] ren_arch,
  input  logic [CNT_W-1:0]             ren_pin_cnt,
  output logic                         ren_stall,
  output logic                         out_valid,
  output logic [$clog2(PHYS_REGS)-1:0] out_new_tag,
  output logic [$clog2(PHYS_REGS)-1:0] out_prev_tag,
  output logic                         err_flag,
  input  logic                         sq_valid,
  input  logic                         sq_fault,
  input  logic                         sq_written,
  input  logic [$clog2(PHYS_REGS)-1:0] sq_tag,
  input  logic                         fl_ret_valid,
  input  logic [$clog2(PHYS_REGS)-1:0] fl_ret_tag
);
  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);
  localparam int FREE_N = PHYS_REGS - ARCH_REGS;

  logic [PW-1:0]    map_q [ARCH_REGS];
  logic [PW-1:0]    cur_tag, head_tag;
  logic [CNT_W-1:0] cur_pin;
  logic             fl_empty, accept, do_alloc, do_reuse;
  ren_path_e        path;

  assign cur_tag = map_q[ren_arch];

  always_comb begin
    if (ren_invalid)               path = RP_INVALID;
    else if (cur_pin == '0)        path = RP_FRESH;
    else if (ren_pin_cnt != '0)    path = RP_DBLPIN;
    else                           path = RP_REUSE;
  end

  assign ren_stall = ren_valid && (sq_valid || ((path == RP_FRESH) && fl_empty));
  assign accept    = ren_valid && !ren_stall;
  assign do_alloc  = accept && (path == RP_FRESH);
  assign do_reuse  = accept && (path == RP_REUSE);

  rmap_free_fifo #(
    .DEPTH(PHYS_REGS), .W(PW), .INIT_LO(ARCH_REGS), .INIT_N(FREE_N)
  ) free_i (
    .clk(clk), .rst(rst),
    .push(fl_ret_valid), .push_tag(fl_ret_tag),
    .pop(do_alloc), .head_tag(head_tag), .empty(fl_empty)
  );

  rmap_pin_table #(
    .PHYS_REGS(PHYS_REGS), .PW(PW), .CNT_W(CNT_W)
  ) pins_i (
    .clk(clk), .rst(rst),
    .rd_tag(cur_tag), .rd_pin(cur_pin),
    .alloc(do_alloc), .reuse(do_reuse),
    .upd_tag(do_alloc ? head_tag : cur_tag), .upd_cnt(ren_pin_cnt),
    .sq_valid(sq_valid), .sq_fault(sq_fault),
    .sq_written(sq_written), .sq_tag(sq_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else if (do_alloc) begin
      map_q[ren_arch] <= head_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_new_tag  <= '0;
      out_prev_tag <= '0;
      err_flag     <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_prev_tag <= cur_tag;
        out_new_tag  <= do_alloc ? head_tag : cur_tag;
        if (path == RP_DBLPIN) err_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmap_chk.sv
module rmap_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          ren_valid,
  input logic          ren_invalid,
  input logic          ren_stall,
  input logic          out_valid,
  input logic [PW-1:0] out_new_tag,
  input logic [PW-1:0] out_prev_tag,
  input logic          err_flag,
  input logic          sq_valid
);
  // R10
  sq_blocks_ren_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && sq_valid) |-> ren_stall);

  // R9
  stall_no_out_chk: assert property (@(posedge clk) disable iff (rst)
    ren_stall |=> !out_valid);

  // R9
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    ren_stall |-> ren_valid);

  // R2
  accept_gives_out_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !ren_stall) |=> out_valid);

  // R3
  invalid_same_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !ren_stall && ren_invalid) |=> (out_new_tag == out_prev_tag));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
endmodule

bind pin_rename_map rmap_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_invalid(ren_invalid),
  .ren_stall(ren_stall), .out_valid(out_valid), .out_new_tag(out_new_tag),
  .out_prev_tag(out_prev_tag), .err_flag(err_flag), .sq_valid(sq_valid)
);

// File: tb/pin_rename_map_tb_top.sv
module pin_rename_map_tb_top;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ren_valid = 0, ren_invalid = 0;
  logic [4:0] ren_arch = '0, ren_pin_cnt = '0;
  logic       ren_stall, out_valid, err_flag;
  logic [5:0] out_new_tag, out_prev_tag;
  logic       sq_valid = 0, sq_fault = 0, sq_written = 0;
  logic [5:0] sq_tag = '0;
  logic       fl_ret_valid = 0;
  logic [5:0] fl_ret_tag = '0;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  int m_map [32];
  int m_pin [64];
  bit m_pinned [64];
  bit m_sqd [64];
  bit m_err;
  int fl [$];
  bit exp_ov;
  int exp_new, exp_prev;

  always #(CLK_NS/2) clk = ~clk;

  pin_rename_map dut_i (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_invalid(ren_invalid),
    .ren_arch(ren_arch), .ren_pin_cnt(ren_pin_cnt), .ren_stall(ren_stall),
    .out_valid(out_valid), .out_new_tag(out_new_tag), .out_prev_tag(out_prev_tag),
    .err_flag(err_flag), .sq_valid(sq_valid), .sq_fault(sq_fault),
    .sq_written(sq_written), .sq_tag(sq_tag), .fl_ret_valid(fl_ret_valid),
    .fl_ret_tag(fl_ret_tag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_map[i] = i;
    for (int t = 0; t < 64; t++) begin
      m_pin[t] = 0; m_pinned[t] = 0; m_sqd[t] = 0;
    end
    fl.delete();
    for (int t = 32; t < 64; t++) fl.push_back(t);
    m_err = 0;
  endtask

  task automatic cyc(input string req, input bit rv, input bit inv, input int arch,
                     input int cnt, input bit sv, input bit sf, input int st,
                     input bit sw, input bit fv, input int ft);
    int cur;
    bit fresh, exp_stall, acc;
    ren_valid = rv; ren_invalid = inv; ren_arch = 5'(arch); ren_pin_cnt = 5'(cnt);
    sq_valid = sv; sq_fault = sf; sq_tag = 6'(st); sq_written = sw;
    fl_ret_valid = fv; fl_ret_tag = 6'(ft);
    cur = m_map[arch];
    fresh = !inv && (m_pin[cur] == 0);
    exp_stall = rv && (sv || (fresh && fl.size() == 0));
    #1;
    chk(req, "ren_stall", int'(ren_stall), int'(exp_stall));
    @(posedge clk);
    acc = rv && !exp_stall;
    if (sv && m_pinned[st] && !m_sqd[st]) begin
      if (sf) m_pin[st] = 0;
      else if (m_pin[st] < 31) m_pin[st]++;
      m_sqd[st] = 1;
    end
    exp_ov = acc;
    if (acc) begin
      exp_prev = cur;
      exp_new = cur;
      if (!inv) begin
        if (m_pin[cur] > 0) begin
          if (cnt != 0) m_err = 1;
          else begin
            m_pin[cur]--;
            m_sqd[cur] = 0;
          end
        end else begin
          exp_new = fl.pop_front();
          m_map[arch] = exp_new;
          m_pin[exp_new] = cnt;
          m_pinned[exp_new] = (cnt != 0);
          m_sqd[exp_new] = 0;
        end
      end
    end
    if (fv && fl.size() < 64) fl.push_back(ft);
    @(negedge clk);
    ren_valid = 0; sq_valid = 0; fl_ret_valid = 0;
    chk(req, "out_valid", int'(out_valid), int'(exp_ov));
    chk(req, "err_flag", int'(err_flag), int'(m_err));
    if (exp_ov) begin
      chk(req, "out_new_tag", int'(out_new_tag), exp_new);
      chk(req, "out_prev_tag", int'(out_prev_tag), exp_prev);
    end
  endtask

  task automatic do_ren(input string req, input int arch, input int cnt);
    cyc(req, 1, 0, arch, cnt, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_inv(input string req, input int arch);
    cyc(req, 1, 1, arch, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_sq(input string req, input int tag, input bit fault, input bit wr);
    cyc(req, 0, 0, 0, 0, 1, fault, tag, wr, 0, 0);
  endtask
  task automatic do_ret(input string req, input int tag);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state at the ports
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "err_flag", int'(err_flag), 0);
    chk("R1", "ren_stall", int'(ren_stall), 0);
    @(negedge clk);
    do_inv("R1", 12);                  // identity mapping 12 -> 12
    do_ren("R1", 3, 0);                // head of free list is 32
    do_inv("R3", 5);
    do_ren("R2", 3, 0);                // fresh 33, previous 32
    // R4: sixteen pinned writes on one tag
    do_ren("R2", 7, 16);               // fresh 34
    for (int k = 0; k < 10; k++) do_ren("R4", 7, 0);
    // R6 re-execution squash, R7 second squash ignored
    do_sq("R6", 34, 0, 1);
    do_sq("R7", 34, 0, 1);
    for (int k = 0; k < 7; k++) do_ren("R4", 7, 0);
    do_ren("R4", 7, 0);                // count exhausted: fresh 35
    do_sq("R6", 35, 0, 0);             // not pinned: no effect
    do_ren("R6", 7, 0);                // still fresh
    // R8 fault squash
    do_ren("R8", 9, 4);
    do_ren("R8", 9, 0);
    do_ren("R8", 9, 0);
    do_sq("R8", m_map[9], 1, 1);
    do_ren("R8", 9, 4);                // fresh, no error
    // R10 squash and rename in the same cycle
    cyc("R10", 1, 0, 9, 0, 1, 0, m_map[9], 1, 0, 0);
    do_ren("R10", 9, 0);
    do_sq("R7", m_map[9], 0, 0);       // applies again after rename
    // R5 double pin
    do_ren("R5", 9, 3);
    do_ren("R5", 9, 0);
    for (int k = 0; k < 6; k++) do_ren("R4", 9, 0);
    // R9 drain the free list
    while (fl.size() > 0) do_ren("R9", 20, 0);
    do_ren("R9", 20, 0);
    // R11 return in the same cycle as a stalled request
    cyc("R11", 1, 0, 20, 0, 0, 0, 0, 0, 1, 3);
    do_ren("R11", 20, 0);
    do_ret("R11", 5);
    do_ret("R11", 6);
    do_ren("R11", 21, 0);
    do_ren("R11", 22, 0);
    do_ren("R9", 23, 0);
    do_inv("R3", 22);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule